// File: doc/BRIEF.md
# Slot-Sampled Pulse-Width Modulator

This block produces an 8-bit pulse-width-modulated level by behaving like a timer interrupt routine running at a fixed sample rate. A prescaler divides the system clock into one-clock ticks, one tick per sample slot, and 256 slots make one period. On every tick three steps run in a fixed order. First, the registered output pin takes the value held in an internal buffer bit. Second, the slot counter is compared with the active duty value, and the buffer bit is set on a match. Third, the counter advances, and the buffer bit is cleared when the counter rolls over. Because of this order, the pin always shows the decision made in the previous slot.

A host writes the duty value through a one-cycle write strobe. The written value becomes active only when the next period begins, so a single period never mixes two duty values. A second output gives a one-clock strobe at the start of each period. A parameter selects the output polarity. With a 5 MHz clock, a prescaler of about 390 gives a 50 Hz period.

Top module: `pwm_slot_gen`

## Requirements
- R1: After reset, the pending duty, the active duty, the slot counter, the buffer bit and the registered output are all zero. While reset is held, `pwm_out` equals INVERT and `period_strobe` is 0.
- R2: A tick occurs once every DIV clocks. `period_strobe` is high for exactly one clock after the tick of slot 0, and consecutive strobes are exactly 256*DIV clocks apart.
- R3: On each tick, the output register first takes the buffer bit as it stood before that tick. With duty d < 255, the pin first becomes active in slot d+1 of the period, which is (d+1)*DIV clocks after the strobe.
- R4: On a tick where the slot counter equals the active duty, the buffer bit is set. On any other tick it is left unchanged, apart from the clear in R5.
- R5: On the tick of slot 255, the counter wraps to 0 and the buffer bit is cleared. This clear wins over a set in the same tick, so duty 255 never activates the pin.
- R6: The pin changes only right after a tick. Within one period it is active for (255-d)*DIV clocks, which is a whole number of slots.
- R7: The value on `duty_wdata` is stored when `duty_we` is high. It takes effect only at the slot-0 tick that follows, so the period in progress keeps its old duty.
- R8: When INVERT=1, `pwm_out` is the bitwise complement of the INVERT=0 output for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_we | input | 1 | Write strobe for the duty value |
| duty_wdata | input | 8 | New duty value |
| pwm_out | output | 1 | Modulated output, polarity set by INVERT |
| period_strobe | output | 1 | One-clock pulse at the start of each period |

## Verification
The period is measured in full at many duty values: the count of active clocks, the offset of the first active slot, and the spacing of the strobes. A wrong slot counter or a stuck buffer bit shows up within one period, as a wrong active width or a wrong first edge. A duty value taken too early shows up in the very period during which it was written, because the bench changes the duty in the middle of a period and checks that this period keeps its old width. An inverted copy of the block is compared against the plain one on every clock.

// File: rtl/pwm_slot_gen.sv
module pwm_slot_gen #(
  parameter int DIV    = 390,
  parameter bit INVERT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       duty_we,
  input  logic [7:0] duty_wdata,
  output logic       pwm_out,
  output logic       period_strobe
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic          tick;
  logic [7:0]    slot_q;
  logic [7:0]    duty_pend;
  logic [7:0]    duty_act;
  logic [7:0]    duty_eff;
  logic          buf_q;
  logic          out_q;
  logic          strobe_q;

  assign tick     = (div_q == DW'(DIV - 1));
  assign duty_eff = (slot_q == 8'd0) ? duty_pend : duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (tick) div_q <= '0;
    else div_q <= div_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_pend <= 8'd0;
    else if (duty_we) duty_pend <= duty_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= 8'd0;
      duty_act <= 8'd0;
      buf_q    <= 1'b0;
      out_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= tick && (slot_q == 8'd0);
      if (tick) begin
        out_q  <= buf_q;
        slot_q <= slot_q + 8'd1;
        if (slot_q == 8'd0) duty_act <= duty_pend;
        if (slot_q == 8'hFF) buf_q <= 1'b0;
        else if (slot_q == duty_eff) buf_q <= 1'b1;
      end
    end
  end

  assign pwm_out       = out_q ^ INVERT;
  assign period_strobe = strobe_q;
endmodule

// File: rtl/pwm_slot_gen_chk.sv
module pwm_slot_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [7:0] slot_q,
  input logic [7:0] duty_eff,
  input logic [7:0] duty_act,
  input logic       buf_q,
  input logic       out_q,
  input logic       strobe
);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  a_r2_strobe_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> slot_q == 8'd1);
  a_r3_lag: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> out_q == $past(buf_q));
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot_q == duty_eff && slot_q != 8'hFF) |=> buf_q);
  a_r5_wrap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot_q == 8'hFF) |=> !buf_q);
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_q));
  a_r7_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && slot_q == 8'd0) |=> $stable(duty_act));
endmodule

bind pwm_slot_gen pwm_slot_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .slot_q   (slot_q),
  .duty_eff (duty_eff),
  .duty_act (duty_act),
  .buf_q    (buf_q),
  .out_q    (out_q),
  .strobe   (period_strobe)
);

// File: tb/tb_pwm_slot_gen.sv
module tb_pwm_slot_gen;
  localparam int DIV = 4;
  localparam int PER = 256 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       duty_we = 1'b0;
  logic [7:0] duty_wdata = 8'd0;
  logic       pwm_out, period_strobe;
  logic       pwm_inv, strobe_inv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_slot_gen #(.DIV(DIV), .INVERT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .duty_we(duty_we), .duty_wdata(duty_wdata),
    .pwm_out(pwm_out), .period_strobe(period_strobe));

  pwm_slot_gen #(.DIV(DIV), .INVERT(1'b1)) dut_inv (
    .clk(clk), .rst_n(rst_n), .duty_we(duty_we), .duty_wdata(duty_wdata),
    .pwm_out(pwm_inv), .period_strobe(strobe_inv));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe();
    @(negedge clk);
    while (!period_strobe) @(negedge clk);
  endtask

  // Entered at the negedge where period_strobe is 1; leaves at the next strobe.
  task automatic measure(input int wr_at, input logic [7:0] wr_val,
                         output int high, output int first, output int strobes,
                         output int pol_bad);
    high = 0; first = -1; strobes = 0; pol_bad = 0;
    for (int i = 0; i < PER; i++) begin
      if (pwm_out) begin
        high++;
        if (first < 0) first = i;
      end
      if (period_strobe) strobes++;
      if (pwm_inv != ~pwm_out) pol_bad++;
      if (i == wr_at) begin duty_we = 1'b1; duty_wdata = wr_val; end
      if (i == wr_at + 1) duty_we = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic int exp_high(input int d);
    return (255 - d) * DIV;
  endfunction

  function automatic int exp_first(input int d);
    return (d == 255) ? -1 : (d + 1) * DIV;
  endfunction

  task automatic write_duty(input logic [7:0] d);
    duty_we = 1'b1; duty_wdata = d;
    @(negedge clk);
    duty_we = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 pwm_out in reset", pwm_out, 0);
    check("R1 period_strobe in reset", period_strobe, 0);
    check("R8 inverted pin in reset", pwm_inv, 1);
    rst_n = 1'b1;
  endtask

  task automatic test_default_duty();
    int h, f, s, p;
    wait_strobe();
    measure(-5, 8'd0, h, f, s, p);
    check("R1 reset duty zero width", h, exp_high(0));
    check("R3 first active slot duty 0", f, exp_first(0));
    check("R2 one strobe per period", s, 1);
    check("R2 strobe spacing", period_strobe, 1);
    check("R8 polarity", p, 0);
  endtask

  task automatic test_duty(input logic [7:0] d, input string req);
    int h, f, s, p;
    write_duty(d);
    wait_strobe();
    measure(-5, 8'd0, h, f, s, p);
    check({req, " width"}, h, exp_high(d));
    check({"R3 first slot ", req}, f, exp_first(d));
    check("R2 strobe spacing", s + period_strobe, 2);
    check("R8 polarity", p, 0);
  endtask

  task automatic test_midwrite();
    int h, f, s, p;
    write_duty(8'd40);
    wait_strobe();
    measure(PER / 2, 8'd200, h, f, s, p);
    check("R7 period keeps old duty", h, exp_high(40));
    measure(-5, 8'd0, h, f, s, p);
    check("R7 new duty next period", h, exp_high(200));
    check("R7 first slot new duty", f, exp_first(200));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_default_duty();
    test_duty(8'd128, "R6 duty 128");
    test_duty(8'd1, "R4 duty 1");
    test_duty(8'd254, "R4 duty 254");
    test_duty(8'd255, "R5 duty 255");
    test_duty(8'd100, "R6 duty 100");
    test_midwrite();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule